// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block drives a display raster. Two counters walk every pixel position of a field. The column counter runs from zero up to a programmed line length, and the row counter steps once for each completed line. Programmable start and stop positions decode those counters into horizontal and vertical sync, horizontal and vertical blanking, and a display-enable flag. The block also outputs the current column and row, so downstream logic can fetch pixels in step with the sync pulses.

Software writes the timing values through a small write-only register port. Each write first lands in a pending copy. The whole pending set moves into the working copy only at a field boundary, so a field is never drawn with a mix of old and new timing. The generator is normally the timing master. When external lock is enabled, a rising edge on an external vertical-sync input forces the raster back to the top-left pixel and also applies the pending settings. A flag reports when the working settings break the range or minimum-width rules.

Top module: `raster_timing`

## Requirements
- R1: The column counter counts 0, 1, …, LTOT and then returns to 0, so one line lasts LTOT+1 clocks. LTOT is written at address 0.
- R2: The row counter advances by one each time the column counter wraps. It counts 0 to FTOT and then returns to 0, so one field lasts FTOT+1 lines. FTOT is written at address 1.
- R3: Horizontal sync is active for columns x with S ≤ x < E, where S is at address 2 and E at address 3. When E < S the active interval wraps, and x ≥ S or x < E applies. Bit 1 of the control word (address 10) inverts the output.
- R4: Vertical sync follows the same interval rule on the row, with start at address 6 and stop at address 7. Bit 2 of the control word inverts it. The output changes only on column 0.
- R5: Horizontal blanking uses addresses 4 and 5 on the column. Vertical blanking uses addresses 8 and 9 on the row and changes only on column 0. Display enable is high exactly when neither blank is active.
- R6: All outputs are registered. The column and row outputs and every decoded signal describe the same raster position, one clock after the counters held that position.
- R7: A write is held pending and joins the working settings only when the counters leave the final pixel of the field, or at an accepted external edge. Until then, timing continues with the old settings.
- R8: When control bit 0 is set in the working settings, a rising edge on ext_vsync_i moves the counters to column 0, row 0 on the next clock and loads the pending settings. When the bit is clear, the edge has no effect.
- R9: cfg_err_o is high when the working settings break a rule. The rules: a sync or blank start is 0 or above its total; a stop is above its total; a sync is active or idle for fewer than 1 position; or a blank is active or idle for fewer than 2 positions.
- R10: While rst_n is low, all outputs are 0 and the working and pending settings take the parameter defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the pending settings |
| cfg_addr | input | 4 | Setting index (0 to 10) |
| cfg_wdata | input | 12 | Write value; bits 2:0 at address 10 are the lock enable, horizontal invert and vertical invert |
| ext_vsync_i | input | 1 | External vertical sync, synchronous to clk |
| hsync_o | output | 1 | Horizontal sync after polarity select |
| vsync_o | output | 1 | Vertical sync after polarity select |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| active_o | output | 1 | Display enable |
| x_o | output | 12 | Column of the position described by the outputs |
| y_o | output | 12 | Row of the position described by the outputs |
| cfg_err_o | output | 1 | Working settings break a timing rule |

## Verification
The decode is tried with two rasters of different sizes. One setting set uses non-wrapping sync intervals with normal polarity. The other uses wrapping intervals for both syncs and inverted polarity, which separates the ordered compare from the wrapped one and shows the inversion bits act on the right output. Writes made in the middle of a field tell the pending copy apart from the working copy: the old line length must still be in force. External edges are applied with lock enabled, where the raster jumps, and with lock disabled, where it keeps counting. A zero start, a one-wide blank and a zero-wide vertical sync each must raise the error flag, and a legal set afterwards must clear it.

// File: rtl/rt_pkg.sv
`timescale 1ns/1ps
package rt_pkg;
    parameter int CW = 12;
    parameter int AW = 4;

    typedef logic [CW-1:0] crd_t;

    typedef struct packed {
        crd_t htot;
        crd_t vtot;
        crd_t hss;
        crd_t hse;
        crd_t hbs;
        crd_t hbe;
        crd_t vss;
        crd_t vse;
        crd_t vbs;
        crd_t vbe;
        logic ext_en;
        logic hinv;
        logic vinv;
    } tcfg_t;

    typedef struct packed {
        crd_t  x;
        crd_t  y;
        tcfg_t act;
        tcfg_t pend;
        logic  ext_q;
        logic  hs;
        logic  vs;
        logic  hb;
        logic  vb;
        logic  de;
        logic  err;
        crd_t  xo;
        crd_t  yo;
    } st_t;

    localparam logic [AW-1:0] A_HTOT = AW'(0);
    localparam logic [AW-1:0] A_VTOT = AW'(1);
    localparam logic [AW-1:0] A_HSS  = AW'(2);
    localparam logic [AW-1:0] A_HSE  = AW'(3);
    localparam logic [AW-1:0] A_HBS  = AW'(4);
    localparam logic [AW-1:0] A_HBE  = AW'(5);
    localparam logic [AW-1:0] A_VSS  = AW'(6);
    localparam logic [AW-1:0] A_VSE  = AW'(7);
    localparam logic [AW-1:0] A_VBS  = AW'(8);
    localparam logic [AW-1:0] A_VBE  = AW'(9);
    localparam logic [AW-1:0] A_CTL  = AW'(10);
endpackage

// File: rtl/rt_span.sv
`timescale 1ns/1ps
// Interval membership on one counter; a stop below the start wraps.
module rt_span #(
    parameter int W = 12
) (
    input  logic [W-1:0] pos,
    input  logic [W-1:0] first,
    input  logic [W-1:0] last,
    output logic         hit
);
    always_comb begin
        if (first <= last) hit = (pos >= first) && (pos < last);
        else               hit = (pos >= first) || (pos < last);
    end
endmodule

// File: rtl/rt_rule.sv
`timescale 1ns/1ps
// Legality of one start/stop pair against its total and a minimum width.
module rt_rule #(
    parameter int W    = 12,
    parameter int MINW = 1
) (
    input  logic [W-1:0] total,
    input  logic [W-1:0] first,
    input  logic [W-1:0] last,
    output logic         bad
);
    logic [W:0] period;
    logic [W:0] on_len;
    logic [W:0] off_len;

    always_comb begin
        period = {1'b0, total} + (W+1)'(1);
        if (last >= first) on_len = {1'b0, last} - {1'b0, first};
        else               on_len = {1'b0, last} + period - {1'b0, first};
        off_len = period - on_len;
        bad = (first == '0) || (first > total) || (last > total) ||
              (on_len < (W+1)'(MINW)) || (off_len < (W+1)'(MINW));
    end
endmodule

// File: rtl/raster_timing.sv
`timescale 1ns/1ps
module raster_timing import rt_pkg::*; #(
    parameter int DEF_HTOT = 799,
    parameter int DEF_VTOT = 524,
    parameter int DEF_HSS  = 656,
    parameter int DEF_HSE  = 752,
    parameter int DEF_HBS  = 640,
    parameter int DEF_HBE  = 0,
    parameter int DEF_VSS  = 490,
    parameter int DEF_VSE  = 492,
    parameter int DEF_VBS  = 480,
    parameter int DEF_VBE  = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    input  logic          ext_vsync_i,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          hblank_o,
    output logic          vblank_o,
    output logic          active_o,
    output logic [CW-1:0] x_o,
    output logic [CW-1:0] y_o,
    output logic          cfg_err_o
);
    localparam int NSIG = 4;  // 0 hsync, 1 hblank, 2 vsync, 3 vblank

    localparam tcfg_t DEF_CFG = '{
        htot: crd_t'(DEF_HTOT), vtot: crd_t'(DEF_VTOT),
        hss:  crd_t'(DEF_HSS),  hse:  crd_t'(DEF_HSE),
        hbs:  crd_t'(DEF_HBS),  hbe:  crd_t'(DEF_HBE),
        vss:  crd_t'(DEF_VSS),  vse:  crd_t'(DEF_VSE),
        vbs:  crd_t'(DEF_VBS),  vbe:  crd_t'(DEF_VBE),
        ext_en: 1'b0, hinv: 1'b0, vinv: 1'b0
    };

    st_t q, d;

    crd_t sp_pos   [NSIG];
    crd_t sp_first [NSIG];
    crd_t sp_last  [NSIG];
    crd_t sp_total [NSIG];
    logic [NSIG-1:0] sp_hit;
    logic [NSIG-1:0] sp_bad;

    always_comb begin
        sp_pos[0] = q.x; sp_first[0] = q.act.hss; sp_last[0] = q.act.hse; sp_total[0] = q.act.htot;
        sp_pos[1] = q.x; sp_first[1] = q.act.hbs; sp_last[1] = q.act.hbe; sp_total[1] = q.act.htot;
        sp_pos[2] = q.y; sp_first[2] = q.act.vss; sp_last[2] = q.act.vse; sp_total[2] = q.act.vtot;
        sp_pos[3] = q.y; sp_first[3] = q.act.vbs; sp_last[3] = q.act.vbe; sp_total[3] = q.act.vtot;
    end

    for (genvar gi = 0; gi < NSIG; gi++) begin : g_sig
        rt_span #(.W(CW)) u_span (
            .pos   (sp_pos[gi]),
            .first (sp_first[gi]),
            .last  (sp_last[gi]),
            .hit   (sp_hit[gi])
        );
        rt_rule #(.W(CW), .MINW(((gi % 2) == 1) ? 2 : 1)) u_rule (
            .total (sp_total[gi]),
            .first (sp_first[gi]),
            .last  (sp_last[gi]),
            .bad   (sp_bad[gi])
        );
    end

    logic resync, line_end, field_end;

    always_comb begin
        d         = q;
        resync    = q.act.ext_en && ext_vsync_i && !q.ext_q;
        line_end  = q.x >= q.act.htot;
        field_end = line_end && (q.y >= q.act.vtot);
        d.ext_q   = ext_vsync_i;

        // registered view of the current position
        d.xo  = q.x;
        d.yo  = q.y;
        d.hs  = sp_hit[0] ^ q.act.hinv;
        d.hb  = sp_hit[1];
        d.vs  = sp_hit[2] ^ q.act.vinv;
        d.vb  = sp_hit[3];
        d.de  = !sp_hit[1] && !sp_hit[3];
        d.err = |sp_bad;

        // raster counters
        if (resync) begin
            d.x = '0;
            d.y = '0;
        end else if (line_end) begin
            d.x = '0;
            d.y = field_end ? '0 : q.y + crd_t'(1);
        end else begin
            d.x = q.x + crd_t'(1);
        end

        // shadow transfer at field start
        if (resync || field_end) d.act = q.pend;

        if (cfg_we) begin
            case (cfg_addr)
                A_HTOT:  d.pend.htot = cfg_wdata;
                A_VTOT:  d.pend.vtot = cfg_wdata;
                A_HSS:   d.pend.hss  = cfg_wdata;
                A_HSE:   d.pend.hse  = cfg_wdata;
                A_HBS:   d.pend.hbs  = cfg_wdata;
                A_HBE:   d.pend.hbe  = cfg_wdata;
                A_VSS:   d.pend.vss  = cfg_wdata;
                A_VSE:   d.pend.vse  = cfg_wdata;
                A_VBS:   d.pend.vbs  = cfg_wdata;
                A_VBE:   d.pend.vbe  = cfg_wdata;
                A_CTL: begin
                    d.pend.ext_en = cfg_wdata[0];
                    d.pend.hinv   = cfg_wdata[1];
                    d.pend.vinv   = cfg_wdata[2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.act  <= DEF_CFG;
            q.pend <= DEF_CFG;
        end else begin
            q <= d;
        end
    end

    assign hsync_o   = q.hs;
    assign vsync_o   = q.vs;
    assign hblank_o  = q.hb;
    assign vblank_o  = q.vb;
    assign active_o  = q.de;
    assign x_o       = q.xo;
    assign y_o       = q.yo;
    assign cfg_err_o = q.err;
endmodule

// File: rtl/rt_chk.sv
`timescale 1ns/1ps
module rt_chk import rt_pkg::*; (
    input logic  clk,
    input logic  rst_n,
    input logic  ext_vsync_i,
    input logic  vsync_o,
    input logic  vblank_o,
    input crd_t  x_o,
    input crd_t  y_o,
    input crd_t  st_x,
    input crd_t  st_y,
    input tcfg_t act,
    input logic  ext_q
);
    AST_X_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_x <= act.htot);  // R1
    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((x_o == $past(x_o) + crd_t'(1)) || (x_o == '0)));  // R1
    AST_Y_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_y <= act.vtot);  // R2
    AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((x_o == '0) || $stable(y_o)));  // R2
    AST_VS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vsync_o) |-> (x_o == '0));  // R4
    AST_VB_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vblank_o) |-> (x_o == '0));  // R5
    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_x != '0) || (st_y != '0)) |-> $stable(act));  // R7
    AST_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (act.ext_en && ext_vsync_i && !ext_q) |=> ((st_x == '0) && (st_y == '0)));  // R8
endmodule

bind raster_timing rt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_vsync_i (ext_vsync_i),
    .vsync_o     (vsync_o),
    .vblank_o    (vblank_o),
    .x_o         (x_o),
    .y_o         (y_o),
    .st_x        (q.x),
    .st_y        (q.y),
    .act         (q.act),
    .ext_q       (q.ext_q)
);

// File: tb/raster_timing_test.sv
`timescale 1ns/1ps
module raster_timing_test;
    localparam int D_HT = 9, D_VT = 5, D_HSS = 6, D_HSE = 8, D_HBS = 7, D_HBE = 0;
    localparam int D_VSS = 3, D_VSE = 4, D_VBS = 2, D_VBE = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic ext_vsync_i = 1'b0;
    logic hsync_o, vsync_o, hblank_o, vblank_o, active_o, cfg_err_o;
    logic [11:0] x_o, y_o;

    raster_timing #(
        .DEF_HTOT(D_HT), .DEF_VTOT(D_VT), .DEF_HSS(D_HSS), .DEF_HSE(D_HSE),
        .DEF_HBS(D_HBS), .DEF_HBE(D_HBE), .DEF_VSS(D_VSS), .DEF_VSE(D_VSE),
        .DEF_VBS(D_VBS), .DEF_VBE(D_VBE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ext_vsync_i(ext_vsync_i), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .hblank_o(hblank_o), .vblank_o(vblank_o),
        .active_o(active_o), .x_o(x_o), .y_o(y_o), .cfg_err_o(cfg_err_o)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_err = 0;
    bit cmp_on = 0;

    task automatic chk(string tag, int act_v, int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int pend[11], act[11];
    int mx, my, m_extq;
    int e_x, e_y, e_hs, e_vs, e_hb, e_vb, e_de, e_err, e_ok;

    function automatic int inside_iv(int p, int s, int e, int t);
        int per = t + 1;
        return (((p - s + per) % per) < ((e - s + per) % per)) ? 1 : 0;
    endfunction

    function automatic int pair_bad(int t, int s, int e, int minw);
        int per = t + 1;
        int w;
        if (s < 1 || s > t || e > t) return 1;
        w = (e - s + per) % per;
        return (w < minw || per - w < minw) ? 1 : 0;
    endfunction

    function automatic int cfg_bad();
        return (pair_bad(act[0], act[2], act[3], 1) | pair_bad(act[0], act[4], act[5], 2) |
                pair_bad(act[1], act[6], act[7], 1) | pair_bad(act[1], act[8], act[9], 2));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pend = '{D_HT, D_VT, D_HSS, D_HSE, D_HBS, D_HBE, D_VSS, D_VSE, D_VBS, D_VBE, 0};
            act  = pend;
            mx = 0; my = 0; m_extq = 0;
            e_x = 0; e_y = 0; e_hs = 0; e_vs = 0; e_hb = 0; e_vb = 0; e_de = 0; e_err = 0; e_ok = 0;
        end else begin
            bit jump, fend;
            e_x = mx; e_y = my;
            e_err = cfg_bad();
            e_ok  = !e_err;
            if (e_ok) begin
                e_hs = inside_iv(mx, act[2], act[3], act[0]) ^ ((act[10] >> 1) & 1);
                e_hb = inside_iv(mx, act[4], act[5], act[0]);
                e_vs = inside_iv(my, act[6], act[7], act[1]) ^ ((act[10] >> 2) & 1);
                e_vb = inside_iv(my, act[8], act[9], act[1]);
                e_de = (!e_hb && !e_vb) ? 1 : 0;
            end
            jump = ((act[10] & 1) != 0) && ext_vsync_i && !m_extq;
            fend = (mx >= act[0]) && (my >= act[1]);
            if (jump) begin mx = 0; my = 0; end
            else if (mx >= act[0]) begin mx = 0; my = fend ? 0 : my + 1; end
            else mx = mx + 1;
            if (jump || fend) act = pend;
            if (cfg_we && cfg_addr <= 10) pend[cfg_addr] = cfg_wdata;
            m_extq = ext_vsync_i;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R1/R6 x", x_o, e_x);
            chk("R2/R6 y", y_o, e_y);
            chk("R9 err", cfg_err_o, e_err);
            if (e_ok) begin
                chk("R3 hsync", hsync_o, e_hs);
                chk("R4 vsync", vsync_o, e_vs);
                chk("R5 hblank", hblank_o, e_hb);
                chk("R5 vblank", vblank_o, e_vb);
                chk("R5 active", active_o, e_de);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(int a, int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 12'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_pos(int xv, int yv);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (x_o == 12'(xv) && y_o == 12'(yv)) return;
        end
        chk("position reached", 0, 1);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 x", x_o, 0);  chk("R10 y", y_o, 0);
        chk("R10 hs", hsync_o, 0); chk("R10 vs", vsync_o, 0);
        chk("R10 hb", hblank_o, 0); chk("R10 vb", vblank_o, 0);
        chk("R10 de", active_o, 0); chk("R10 err", cfg_err_o, 0);
        rst_n = 1'b1;
        cmp_on = 1;
        idle(130);

        // R7: mid-field writes must not alter the running line length
        wait_pos(0, 1);
        wr(0, 15); wr(1, 7); wr(2, 13); wr(3, 2); wr(4, 11); wr(5, 15);
        wr(6, 6); wr(7, 1); wr(8, 5); wr(9, 0); wr(10, 7);
        wait_pos(9, y_o < 12'd5 ? int'(y_o) : 0);
        @(negedge clk);
        chk("R7 old line length kept", x_o, 0);
        idle(400);

        // R8: lock enabled, edge realigns
        wait_pos(5, 3);
        ext_vsync_i = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R8 resync x", x_o, 0);
        chk("R8 resync y", y_o, 0);
        idle(5);
        ext_vsync_i = 1'b0;
        idle(20);

        // R8: lock disabled, edge ignored
        wr(10, 6);
        idle(300);
        wait_pos(5, 3);
        ext_vsync_i = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R8 ignored x", x_o, 7);
        chk("R8 ignored y", y_o, 3);
        ext_vsync_i = 1'b0;
        idle(10);

        // R9: rule violations
        wr(4, 0);
        idle(300);
        chk("R9 zero start", cfg_err_o, 1);
        wr(4, 14);
        idle(300);
        chk("R9 narrow blank", cfg_err_o, 1);
        wr(4, 11); wr(7, 6);
        idle(300);
        chk("R9 empty vsync", cfg_err_o, 1);
        wr(7, 1);
        idle(300);
        chk("R9 legal again", cfg_err_o, 0);
        idle(50);

        cmp_on = 0;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule